// File: doc/BRIEF.md
# Levenshtein approximate string matcher

This block scans a stream of 8-bit symbols for places where a fixed pattern of length N appears with at most M edits, where an edit is an inserted, a deleted or a substituted symbol. Every accepted symbol advances a grid of M+1 rows by N-M columns at once. Row e means that e edits have been spent so far. Each grid cell holds two one-bit activity elements. The exact element fires only when the incoming symbol equals the cell's pattern symbol. The any-symbol element fires on every symbol and carries the insertion and substitution paths. Deletions and runs of errors are handled by fixed links between cells, so no extra clock cycle is spent on them.

The pattern lives in a small store with one symbol per position, and that store can be rewritten at run time. The same grid therefore serves any pattern of the same N and M. The block reports a one-cycle match pulse together with the lowest edit row that reported. The intended use is a filter in front of a slower exact checker: a pulse marks the symbol at which a close alignment completes.

Top module: `lev_matcher`

## Requirements
- R1: While reset is held and on the first cycle after it, `match` is 0 and `match_row` is 0. No partial alignment survives reset.
- R2: When the first N-M pattern symbols arrive in a row without error, `match` is 1 with `match_row` 0 in the cycle after the last of them is accepted.
- R3: An alignment with one substitution, one inserted stream symbol or one skipped pattern symbol is reported with `match_row` 1. The report comes on the symbol that equals pattern position N-M.
- R4: An alignment with e edits (e at most M) is reported with `match_row` e. The report comes on the symbol that equals pattern position N-M-1+e.
- R5: A stream stretch that needs more than M edits against every pattern prefix produces no match.
- R6: When several rows report on the same symbol, `match_row` is the lowest of them.
- R7: A cycle with `sym_valid` low neither advances nor clears the alignment state and raises no match. `match` is high for at most one cycle per accepted symbol.
- R8: Whenever `match` is 0, `match_row` is 0.
- R9: A write with `wr_en` high and `sym_valid` low stores `wr_sym` at pattern position `wr_addr` (position 0 is the first pattern symbol). Symbols accepted from the next cycle on are compared with the new pattern.
- R10: A write offered in a cycle when `sym_valid` is high is dropped and leaves the pattern unchanged.
- R11: A match in row e is reported only when the accepted symbol equals pattern position N-M-1+e. An alignment never completes on an error symbol.
- R12: On every cycle, the match outputs equal those of the alignment rule. That rule tracks every partial alignment of the pattern against the stream whose count of consumed pattern symbols minus edits stays within 0..N-M. It reports whenever one of these alignments reaches N-M+e consumed pattern symbols with e edits, through an exact symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sym_valid | input | 1 | A stream symbol is offered this cycle |
| sym_in | input | 8 | Stream symbol |
| wr_en | input | 1 | Pattern store write request |
| wr_addr | input | $clog2(N) | Pattern position to write |
| wr_sym | input | 8 | Symbol to store |
| match | output | 1 | One-cycle pulse: an alignment completed on the last accepted symbol |
| match_row | output | $clog2(M+1) | Lowest edit count among the completed alignments, 0 when no match |

## Verification
A wrong activity bit in the grid can stay hidden for a long time. It becomes visible at the ports only when it propagates to the last column, which takes up to N-M further accepted symbols. By then it shows as a spurious pulse, a missing pulse, or a row number that is too high or too low. For this reason, a reference model of the alignment rule is compared on every clock over a long random stream drawn from the pattern alphabet, so that stray bits reach the last column often. Directed streams place one and two edits of each kind next to the final column, where a wrong deletion or insertion link changes the reported row on the very next symbol.

// File: rtl/lev_pkg.sv
// Shared symbol type for the approximate matcher.
package lev_pkg;
    localparam int SYM_W = 8;
    typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/lev_pattern_store.sv
// Pattern symbol store, one entry per pattern position.
// Assumes writes are only legal while no stream symbol is offered; a write
// that arrives together with a symbol is dropped.
module lev_pattern_store #(
    parameter int N  = 8,
    parameter int AW = $clog2(N)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic                          busy,
    input  logic [AW-1:0]                 wr_addr,
    input  lev_pkg::sym_t                 wr_sym,
    output logic [N-1:0][lev_pkg::SYM_W-1:0] pat_q
);
    // Store one symbol when idle and the position is in range.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pat_q <= '0;
        end else if (wr_en && !busy && (int'(wr_addr) < N)) begin
            pat_q[wr_addr] <= wr_sym;
        end
    end
endmodule

// File: rtl/lev_cell.sv
// One grid cell: an exact-symbol element and an any-symbol element.
// The exact element fires when armed and the symbol equals its label; the
// any-symbol element fires whenever armed. Row-0 cells have no any-symbol
// element (HAS_WILD = 0). State only moves on accepted symbols.
module lev_cell #(
    parameter bit HAS_WILD = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  lev_pkg::sym_t sym,
    input  lev_pkg::sym_t label,
    input  logic          char_arm,
    input  logic          wild_arm,
    output logic          char_q,
    output logic          wild_q
);
    // Advance both elements on an accepted symbol.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            char_q <= 1'b0;
            wild_q <= 1'b0;
        end else if (step) begin
            char_q <= char_arm && (sym == label);
            wild_q <= HAS_WILD && wild_arm;
        end
    end
endmodule

// File: rtl/lev_row_pick.sv
// Picks the lowest set row from the last-column hits.
module lev_row_pick #(
    parameter int ROWS = 3,
    parameter int RW   = $clog2(ROWS)
) (
    input  logic [ROWS-1:0] hits,
    output logic            any,
    output logic [RW-1:0]   row
);
    // Scan from the top row down so the lowest hit wins.
    always_comb begin
        any = |hits;
        row = '0;
        for (int r = ROWS - 1; r >= 0; r--) begin
            if (hits[r]) row = RW'(r);
        end
    end
endmodule

// File: rtl/lev_matcher.sv
// Approximate matcher top: (M+1) x (N-M) grid of cells.
// Cell (i,j) compares against pattern position i+j. A cell is "landed"
// when either element is set; landed states are closed along the column
// (row i sees every landed state at or below it) to realise skipped
// pattern symbols without extra cycles. Column -1 (no lag) is always live.
// Assumes 1 <= M < N.
module lev_matcher #(
    parameter int N = 8,
    parameter int M = 2,
    localparam int K  = N - M,
    localparam int AW = $clog2(N),
    localparam int RW = $clog2(M + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sym_valid,
    input  logic [lev_pkg::SYM_W-1:0] sym_in,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  logic [lev_pkg::SYM_W-1:0] wr_sym,
    output logic                      match,
    output logic [RW-1:0]             match_row
);
    logic [N-1:0][lev_pkg::SYM_W-1:0] pat_q;
    logic char_st  [M+1][K];
    logic wild_st  [M+1][K];
    logic char_arm [M+1][K];
    logic wild_arm [M+1][K];
    logic live     [M+1][K+2];
    logic [M:0]    last_hit;
    logic          hit_any;
    logic [RW-1:0] hit_row;
    logic          fresh_q;

    lev_pattern_store #(.N(N), .AW(AW)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .busy(sym_valid),
        .wr_addr(wr_addr), .wr_sym(wr_sym), .pat_q(pat_q)
    );

    // Column closure: live[i][c] for lag c; c=0 always live, c=K+1 pruned.
    always_comb begin
        for (int i = 0; i <= M; i++) begin
            live[i][0]   = 1'b1;
            live[i][K+1] = 1'b0;
        end
        for (int j = 0; j < K; j++) begin
            logic acc;
            acc = 1'b0;
            for (int i = 0; i <= M; i++) begin
                acc = acc | char_st[i][j] | wild_st[i][j];
                live[i][j+1] = acc;
            end
        end
    end

    // Arming: exact from the column to the left, same row; any-symbol from
    // the row below, same column (substitution) or one column right (insertion).
    always_comb begin
        for (int j = 0; j < K; j++) begin
            for (int i = 0; i <= M; i++) char_arm[i][j] = live[i][j];
            wild_arm[0][j] = 1'b0;
            for (int i = 1; i <= M; i++)
                wild_arm[i][j] = live[i-1][j+1] | live[i-1][j+2];
        end
    end

    for (genvar gi = 0; gi <= M; gi++) begin : g_row
        for (genvar gj = 0; gj < K; gj++) begin : g_col
            lev_cell #(.HAS_WILD(gi > 0)) u_cell (
                .clk(clk), .rst_n(rst_n), .step(sym_valid), .sym(sym_in),
                .label(pat_q[gi+gj]),
                .char_arm(char_arm[gi][gj]), .wild_arm(wild_arm[gi][gj]),
                .char_q(char_st[gi][gj]), .wild_q(wild_st[gi][gj])
            );
        end
        assign last_hit[gi] = char_st[gi][K-1];
    end

    lev_row_pick #(.ROWS(M + 1), .RW(RW)) u_pick (
        .hits(last_hit), .any(hit_any), .row(hit_row)
    );

    // Marks that the grid moved on the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) fresh_q <= 1'b0;
        else        fresh_q <= sym_valid;
    end

    assign match     = fresh_q && hit_any;
    assign match_row = match ? hit_row : '0;
endmodule

// File: rtl/lev_matcher_chk.sv
// Port-level properties of the matcher, bound to every instance.
module lev_matcher_chk #(
    parameter int N = 8,
    parameter int M = 2,
    localparam int K  = N - M,
    localparam int RW = $clog2(M + 1)
) (
    input logic                                clk,
    input logic                                rst_n,
    input logic                                sym_valid,
    input logic [lev_pkg::SYM_W-1:0]           sym_in,
    input logic                                wr_en,
    input logic                                match,
    input logic [RW-1:0]                       match_row,
    input logic [N-1:0][lev_pkg::SYM_W-1:0]    pat_q
);
    // R1: quiet on the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!match && match_row == '0));
    // R7: a pulse only follows an accepted symbol
    p_pulse_after_symbol_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> $past(sym_valid));
    // R8: row is zero without a match
    p_quiet_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !match |-> (match_row == '0));
    // R4: reported row within the grid
    p_row_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> (int'(match_row) <= M));
    // R11: the completing symbol is the row's last pattern symbol
    p_exact_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        match |-> ($past(sym_in) == pat_q[K - 1 + int'(match_row)]));
    // R10: blocked write leaves the pattern as it was
    p_write_blocked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sym_valid) |=> $stable(pat_q));
endmodule

bind lev_matcher lev_matcher_chk #(.N(N), .M(M)) u_chk (
    .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
    .wr_en(wr_en), .match(match), .match_row(match_row), .pat_q(pat_q)
);

// File: tb/sim_lev_matcher.sv
`timescale 1ns/1ps
// Bench: behavioural alignment model compared on every clock, plus directed checks.
module sim_lev_matcher;
    localparam int N  = 8;
    localparam int M  = 2;
    localparam int K  = N - M;
    localparam int AW = $clog2(N);
    localparam int RW = $clog2(M + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sym_valid = 1'b0;
    logic [7:0] sym_in = '0;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_sym = '0;
    logic match;
    logic [RW-1:0] match_row;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bit   alive [0:M][0:N];
    byte unsigned pat_m [0:N-1];
    bit   exp_m;
    int   exp_r;

    always #2 clk = ~clk;

    lev_matcher #(.N(N), .M(M)) u0 (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_in(sym_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_sym(wr_sym),
        .match(match), .match_row(match_row)
    );

    task automatic check(input bit ok, input string req, input int am, input int ar,
                         input int em, input int er);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: match=%0d row=%0d expected match=%0d row=%0d", req, am, ar, em, er);
        end
    endtask

    task automatic model_reset();
        for (int e = 0; e <= M; e++)
            for (int p = 0; p <= N; p++) alive[e][p] = (p <= e);
        for (int k = 0; k < N; k++) pat_m[k] = 8'h00;
    endtask

    // One accepted symbol through the alignment rule.
    task automatic model_step(input byte unsigned c, output bit m, output int r);
        bit land [0:M][0:N];
        bit nxt  [0:M][0:N];
        m = 0; r = 0;
        for (int e = 0; e <= M; e++) begin
            for (int p = 0; p <= N; p++) begin
                land[e][p] = 0;
                if (p >= 1 && p - e >= 1 && p - e <= K) begin
                    bit mt, er;
                    mt = alive[e][p-1] && (c == pat_m[p-1]);
                    er = (e > 0) && (alive[e-1][p] || alive[e-1][p-1]);
                    land[e][p] = mt || er;
                    if (mt && (p - e == K) && !m) begin m = 1; r = e; end
                end
            end
        end
        for (int e = 0; e <= M; e++)
            for (int p = 0; p <= N; p++) begin
                if (p <= e) nxt[e][p] = 1;
                else if (p - e > K) nxt[e][p] = 0;
                else nxt[e][p] = land[e][p] || (e > 0 && nxt[e-1][p-1]);
            end
        for (int e = 0; e <= M; e++)
            for (int p = 0; p <= N; p++) alive[e][p] = nxt[e][p];
    endtask

    // Drive one cycle, advance the model, compare after the edge (R12).
    task automatic cyc(input bit v, input byte unsigned c, input bit w,
                       input int a, input byte unsigned d);
        sym_valid = v; sym_in = c; wr_en = w; wr_addr = AW'(a); wr_sym = d;
        exp_m = 0; exp_r = 0;
        if (v) model_step(c, exp_m, exp_r);
        else if (w) pat_m[a] = d;
        @(negedge clk);
        check(match == exp_m && int'(match_row) == exp_r, "R12 model",
              match, match_row, exp_m, exp_r);
        sym_valid = 0; wr_en = 0;
    endtask

    task automatic feed(input string s);
        for (int k = 0; k < s.len(); k++) cyc(1, s[k], 0, 0, 0);
    endtask

    task automatic load(input string s);
        for (int k = 0; k < N; k++) cyc(0, 0, 1, k, s[k]);
    endtask

    task automatic expect_out(input int em, input int er, input string req);
        check(match == em && int'(match_row) == er, req, match, match_row, em, er);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        expect_out(0, 0, "R1 in reset");
        rst_n = 1;
        @(negedge clk);
        expect_out(0, 0, "R1 after reset");

        load("abcdefgh");
        feed("xxabcde"); cyc(1, "f", 0, 0, 0); expect_out(1, 0, "R2 exact prefix");
        feed("zzzz");
        feed("abc");
        for (int k = 0; k < 3; k++) begin
            cyc(0, "f", 0, 0, 0); expect_out(0, 0, "R7 idle no pulse");
        end
        feed("de"); cyc(1, "f", 0, 0, 0); expect_out(1, 0, "R7 state held over idle");
        cyc(0, 0, 0, 0, 0); expect_out(0, 0, "R7 single pulse");
        feed("zzzz");
        feed("abXdef"); cyc(1, "g", 0, 0, 0); expect_out(1, 1, "R3 substitution");
        feed("zzzz");
        feed("abcXdef"); cyc(1, "g", 0, 0, 0); expect_out(1, 1, "R3 insertion");
        feed("zzzz");
        feed("abdef"); cyc(1, "g", 0, 0, 0); expect_out(1, 1, "R3 deletion");
        feed("zzzz");
        feed("aXcYefg"); cyc(1, "h", 0, 0, 0); expect_out(1, 2, "R4 two edits");
        feed("zzzz");
        feed("aXcYeZg"); cyc(1, "h", 0, 0, 0); expect_out(0, 0, "R5 three edits");
        feed("zzzz");
        feed("abcde"); cyc(1, "X", 0, 0, 0); expect_out(0, 0, "R11 no end on error");
        feed("zzzz");

        load("abcdeffh");
        feed("abcde"); cyc(1, "f", 0, 0, 0); expect_out(1, 0, "R6 lowest row");
        feed("zzzz");

        load("qrstuvwx");
        feed("abcde"); cyc(1, "f", 0, 0, 0); expect_out(0, 0, "R9 old pattern gone");
        feed("zzzz");
        feed("qrstu"); cyc(1, "v", 0, 0, 0); expect_out(1, 0, "R9 new pattern");
        feed("zzzz");
        cyc(1, "q", 1, 5, "k");
        feed("rstu"); cyc(1, "v", 0, 0, 0); expect_out(1, 0, "R10 write dropped");
        feed("zzzz");

        load("abcdefgh");
        for (int k = 0; k < 4000; k++) begin
            int x;
            x = $urandom_range(0, 9);
            if (x == 9) cyc(0, 0, 0, 0, 0);
            else cyc(1, 8'(97 + $urandom_range(0, 8)), 0, 0, 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule